// File: doc/BRIEF.md
# Conditional Branch and Call Sequencer

This block owns the program counter of a small signal-processing core with a 14-bit program address space. Each cycle in which an instruction retires (`step_en` high), it decides the next program address. For an ordinary instruction that address is the following word. For a jump-class instruction it decodes a 9-bit jump type and does one of several things. It can test a condition and branch, jump unconditionally into either half of the address space, or call a subroutine. It can also jump indirectly to the value held in the serial-output register.

Conditions come from three sources: the six flags of each of the two accumulators, the low nibble of the data pointer, and three interface status bits. A call saves the return address in a small circular stack. An instruction that carries the return flag takes the next address back from that stack. The stack pointer wraps silently modulo the stack depth, so a deep call chain overwrites the oldest entries. The ALU, the flag logic and the instruction fetch live outside this block. They supply the flags, the nibble, the status bits and the decoded instruction word.

Top module: `pc_sequencer`

## Requirements
- R1: A synchronous active-high reset sets `pc` and `sp` to 0.
- R2: While `step_en` is low, `pc` and `sp` keep their values whatever the other inputs are.
- R3: A retiring instruction with neither `is_jump` nor `is_ret` sets `pc` to `pc`+1 modulo 2^14, so 0x3FFF is followed by 0x0000.
- R4: The branch target is {bit 13 of `pc`+1, `jop[1:0]`, `jop[12:2]`}, with `jop[1:0]` as target bits 12:11. A taken conditional branch loads this target, and a false condition gives `pc`+1.
- R5: The jump type is `jop[21:13]`. Flag tests use the even types 0x80 through 0xAE, type = 0x80 + 8*f + 4*a + 2*s. Here f is the flag index, a selects the accumulator (0 for `flags_a`, 1 for `flags_b`), and s=1 branches when the flag is 1 (s=0 when it is 0). Flag bit positions are: 0 carry, 1 zero, 2 overflow0, 3 overflow1, 4 sign0, 5 sign1.
- R6: Data-pointer nibble tests on `dp_nib`: type 0xB0 branches when it is 0, 0xB1 when it is not 0, 0xB2 when it is 0xF, and 0xB3 when it is not 0xF.
- R7: Status tests: types 0xB4/0xB6 test `ser_in_ctl`, 0xB8/0xBA test `ser_out_ctl`, and 0xBC/0xBE test `host_req`. In each pair the lower type branches when the bit is 0 and the higher type when it is 1.
- R8: Type 0x100 jumps to the target with bit 13 forced to 0, and type 0x101 jumps with bit 13 forced to 1, both unconditionally.
- R9: Types 0x140 and 0x141 write `pc`+1 into the stack entry at `sp`, advance `sp` by one modulo the stack depth, and jump to the target with bit 13 forced to 0 or 1 respectively.
- R10: An instruction with `is_ret` high and `is_jump` low decrements `sp` modulo the stack depth and loads `pc` from the entry at the decremented pointer. An entry overwritten by a wrapped call returns the newer value.
- R11: Jump type 0x000 loads `pc` from `sout`.
- R12: Jump types not named above advance `pc` by one, and when `is_jump` and `is_ret` are both high the jump decode is used and the stack is untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | An instruction retires this cycle |
| is_jump | input | 1 | Retiring instruction is jump-class |
| is_ret | input | 1 | Retiring instruction carries the return flag |
| jop | input | 22 | Instruction word bits: type 21:13, address 12:2, bank 1:0 |
| flags_a | input | 6 | Accumulator A flags: carry, zero, ov0, ov1, sign0, sign1 (bit 0 up) |
| flags_b | input | 6 | Accumulator B flags, same order |
| dp_nib | input | 4 | Low nibble of the data pointer |
| ser_in_ctl | input | 1 | Serial-input control status bit |
| ser_out_ctl | input | 1 | Serial-output control status bit |
| host_req | input | 1 | Host request status bit |
| sout | input | 14 | Serial-output register, indirect jump source |
| pc | output | 14 | Program counter (registered) |
| sp | output | $clog2(STACK_DEPTH) | Return stack pointer (registered) |

## Verification
The bench walks every even flag-test type against all-clear, all-set and alternating flag patterns. A decoder that swapped the accumulators, inverted a polarity or mapped a flag to the wrong slot would then branch where it should fall through. The data-pointer and status tests are also run with values on both sides of each condition. A branch taken from 0x1FFF must land in the upper half, which shows that bit 13 comes from the incremented counter and not the old one. Five nested calls into a four-deep stack force the pointer to wrap, and the unwinding returns must then yield the overwritten entry twice. A design with a saturating pointer or a stale entry would return to the wrong address. Undefined types, a jump with the return flag also set, and stalled cycles that carry jump opcodes are checked to leave the stack and counter alone or merely advance the counter.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  localparam int PC_W   = 14;
  localparam int FLAG_W = 6;
  localparam int JT_W   = 9;

  typedef logic [PC_W-1:0] pc_t;
  typedef logic [JT_W-1:0] jtype_t;

  localparam jtype_t JT_SOUT  = 9'h000;
  localparam jtype_t JT_FAR0  = 9'h100;
  localparam jtype_t JT_FAR1  = 9'h101;
  localparam jtype_t JT_CALL0 = 9'h140;
  localparam jtype_t JT_CALL1 = 9'h141;
endpackage

// File: rtl/branch_cond.sv
module branch_cond
  import pc_seq_pkg::*;
(
  input  jtype_t            jtype,
  input  logic [FLAG_W-1:0] flags_a,
  input  logic [FLAG_W-1:0] flags_b,
  input  logic [3:0]        dp_nib,
  input  logic              ser_in_ctl,
  input  logic              ser_out_ctl,
  input  logic              host_req,
  output logic              cond_valid,
  output logic              cond_true
);
  logic [4:0]        k;
  logic [FLAG_W-1:0] fsel;
  logic [3:0]        stat;

  assign k    = jtype[5:1];
  assign fsel = k[1] ? flags_b : flags_a;
  assign stat = {host_req, ser_out_ctl, ser_in_ctl, 1'b0};

  always_comb begin
    cond_valid = 1'b0;
    cond_true  = 1'b0;
    if (jtype[8:2] == 7'b0101100) begin
      cond_valid = 1'b1;
      case (jtype[1:0])
        2'd0:    cond_true = (dp_nib == 4'h0);
        2'd1:    cond_true = (dp_nib != 4'h0);
        2'd2:    cond_true = (dp_nib == 4'hF);
        default: cond_true = (dp_nib != 4'hF);
      endcase
    end else if (jtype[8:6] == 3'b010 && !jtype[0]) begin
      if (k < 5'd24) begin
        cond_valid = 1'b1;
        cond_true  = (fsel[k[4:2]] == k[0]);
      end else if (k >= 5'd26) begin
        cond_valid = 1'b1;
        cond_true  = (stat[k[2:1]] == k[0]);
      end
    end
  end
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 14,
  localparam int SPW  = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           push,
  input  logic           pop,
  input  logic [W-1:0]   wdata,
  output logic [W-1:0]   rdata,
  output logic [SPW-1:0] sp
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (push) mem[sp] <= wdata;
  end

  assign rdata = mem[sp - SPW'(1)];

  always_ff @(posedge clk) begin
    if (rst)       sp <= '0;
    else if (push) sp <= sp + SPW'(1);
    else if (pop)  sp <= sp - SPW'(1);
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pc_seq_pkg::*;
#(
  parameter int STACK_DEPTH = 8,
  localparam int SPW = $clog2(STACK_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic              is_jump,
  input  logic              is_ret,
  input  logic [21:0]       jop,
  input  logic [FLAG_W-1:0] flags_a,
  input  logic [FLAG_W-1:0] flags_b,
  input  logic [3:0]        dp_nib,
  input  logic              ser_in_ctl,
  input  logic              ser_out_ctl,
  input  logic              host_req,
  input  logic [PC_W-1:0]   sout,
  output logic [PC_W-1:0]   pc,
  output logic [SPW-1:0]    sp
);
  pc_t    pc_inc, target, pc_nxt, stk_top;
  jtype_t jtype;
  logic   cvalid, ctrue, push, pop;

  assign pc_inc = pc + PC_W'(1);
  assign jtype  = jop[21:13];
  assign target = {pc_inc[PC_W-1], jop[1:0], jop[12:2]};

  branch_cond u_cond (
    .jtype(jtype), .flags_a(flags_a), .flags_b(flags_b), .dp_nib(dp_nib),
    .ser_in_ctl(ser_in_ctl), .ser_out_ctl(ser_out_ctl), .host_req(host_req),
    .cond_valid(cvalid), .cond_true(ctrue)
  );

  ret_stack #(.DEPTH(STACK_DEPTH), .W(PC_W)) u_stack (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .wdata(pc_inc), .rdata(stk_top), .sp(sp)
  );

  always_comb begin
    pc_nxt = pc;
    push   = 1'b0;
    pop    = 1'b0;
    if (step_en) begin
      if (is_jump) begin
        case (jtype)
          JT_SOUT:  pc_nxt = sout;
          JT_FAR0:  pc_nxt = {1'b0, target[PC_W-2:0]};
          JT_FAR1:  pc_nxt = {1'b1, target[PC_W-2:0]};
          JT_CALL0: begin push = 1'b1; pc_nxt = {1'b0, target[PC_W-2:0]}; end
          JT_CALL1: begin push = 1'b1; pc_nxt = {1'b1, target[PC_W-2:0]}; end
          default:  pc_nxt = (cvalid && ctrue) ? target : pc_inc;
        endcase
      end else if (is_ret) begin
        pop    = 1'b1;
        pc_nxt = stk_top;
      end else begin
        pc_nxt = pc_inc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_nxt;
  end
endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
  parameter int STACK_DEPTH = 8,
  localparam int SPW = $clog2(STACK_DEPTH)
) (
  input logic           clk,
  input logic           rst,
  input logic           step_en,
  input logic           is_jump,
  input logic           is_ret,
  input logic [21:0]    jop,
  input logic [13:0]    pc,
  input logic [SPW-1:0] sp
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc == 14'd0 && sp == '0));

  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> ($stable(pc) && $stable(sp)));

  assert_plain_step_R3: assert property (@(posedge clk) disable iff (rst)
    (step_en && !is_jump && !is_ret) |=> (pc == $past(pc) + 14'd1));

  assert_far_high_R8: assert property (@(posedge clk) disable iff (rst)
    (step_en && is_jump && jop[21:13] == 9'h101)
      |=> (pc[13] && pc[12:0] == $past({jop[1:0], jop[12:2]})));

  assert_call_push_R9: assert property (@(posedge clk) disable iff (rst)
    (step_en && is_jump && (jop[21:13] == 9'h140 || jop[21:13] == 9'h141))
      |=> (sp == $past(sp) + SPW'(1)));

  assert_ret_pop_R10: assert property (@(posedge clk) disable iff (rst)
    (step_en && !is_jump && is_ret) |=> (sp == $past(sp) - SPW'(1)));
endmodule

bind pc_sequencer pc_sequencer_chk #(.STACK_DEPTH(STACK_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .step_en(step_en), .is_jump(is_jump), .is_ret(is_ret),
  .jop(jop), .pc(pc), .sp(sp)
);

// File: tb/pc_sequencer_bench.sv
module pc_sequencer_bench;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_en = 1'b0, is_jump = 1'b0, is_ret = 1'b0;
  logic [21:0] jop = '0;
  logic [5:0]  fa = '0, fb = '0;
  logic [3:0]  dpn = '0;
  logic        sic = 1'b0, soc = 1'b0, rqm = 1'b0;
  logic [13:0] sout = '0;
  logic [13:0] pc;
  logic [1:0]  sp;

  pc_sequencer #(.STACK_DEPTH(DEPTH)) u_pc_sequencer (
    .clk(clk), .rst(rst), .step_en(step_en), .is_jump(is_jump), .is_ret(is_ret),
    .jop(jop), .flags_a(fa), .flags_b(fb), .dp_nib(dpn),
    .ser_in_ctl(sic), .ser_out_ctl(soc), .host_req(rqm), .sout(sout),
    .pc(pc), .sp(sp)
  );

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  logic [13:0] m_pc = '0;
  logic [1:0]  m_sp = '0;
  logic [13:0] m_stk [DEPTH];

  logic [13:0] q_pc [$];
  logic [1:0]  q_sp [$];
  string       q_tag [$];

  function automatic logic [1:0] model_cond(input logic [8:0] ty);
    int n;
    logic [5:0] v;
    logic want;
    if (ty >= 9'h080 && ty <= 9'h0AE && ty[0] == 1'b0) begin
      n = (int'(ty) - 'h80) / 2;
      v = ((n % 4) / 2 == 1) ? fb : fa;
      want = (n % 2 == 1);
      return {1'b1, v[n / 4] == want};
    end
    if (ty == 9'h0B0) return {1'b1, dpn == 4'h0};
    if (ty == 9'h0B1) return {1'b1, dpn != 4'h0};
    if (ty == 9'h0B2) return {1'b1, dpn == 4'hF};
    if (ty == 9'h0B3) return {1'b1, dpn != 4'hF};
    if (ty >= 9'h0B4 && ty <= 9'h0BE && ty[0] == 1'b0) begin
      n = (int'(ty) - 'hB4) / 2;
      want = (n % 2 == 1);
      case (n / 2)
        0:       return {1'b1, sic == want};
        1:       return {1'b1, soc == want};
        default: return {1'b1, rqm == want};
      endcase
    end
    return 2'b00;
  endfunction

  task automatic issue(input logic en, input logic j, input logic r,
                       input logic [8:0] ty, input logic [12:0] tl, input string tag);
    logic [13:0] inc;
    logic [1:0]  c;
    inc = m_pc + 14'd1;
    c = model_cond(ty);
    if (en) begin
      if (j) begin
        if (ty == 9'h000)      m_pc = sout;
        else if (ty == 9'h100) m_pc = {1'b0, tl};
        else if (ty == 9'h101) m_pc = {1'b1, tl};
        else if (ty == 9'h140 || ty == 9'h141) begin
          m_stk[m_sp] = inc;
          m_sp = m_sp + 2'd1;
          m_pc = {ty[0], tl};
        end else if (c == 2'b11) m_pc = {inc[13], tl};
        else                     m_pc = inc;
      end else if (r) begin
        m_sp = m_sp - 2'd1;
        m_pc = m_stk[m_sp];
      end else m_pc = inc;
    end
    step_en = en; is_jump = j; is_ret = r;
    jop = {ty, tl[10:0], tl[12:11]};
    @(posedge clk);
    #1;
    q_pc.push_back(m_pc);
    q_sp.push_back(m_sp);
    q_tag.push_back(tag);
    step_en = 1'b0; is_jump = 1'b0; is_ret = 1'b0;
  endtask

  always @(negedge clk) begin
    if (q_pc.size() > 0) begin
      logic [13:0] ep;
      logic [1:0]  es;
      string t;
      ep = q_pc.pop_front();
      es = q_sp.pop_front();
      t  = q_tag.pop_front();
      tests++;
      if (pc !== ep || sp !== es) begin
        fails++;
        $display("FAIL %s: pc=%h sp=%0d expected pc=%h sp=%0d", t, pc, sp, ep, es);
      end
    end
  end

  task automatic check_reset(input string tag);
    @(negedge clk);
    tests++;
    if (pc !== 14'd0 || sp !== 2'd0) begin
      fails++;
      $display("FAIL %s: pc=%h sp=%0d expected pc=0000 sp=0", tag, pc, sp);
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++;
        $display("FAIL watchdog: cycles=%0d expected < 100000", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    check_reset("R1 after power-up reset");

    // R3: plain increments
    for (int i = 0; i < 3; i++) issue(1, 0, 0, 9'h000, 13'h0, "R3 plain step");
    // R2: stalled cycles carrying jump/call/ret
    issue(0, 1, 0, 9'h101, 13'h0777, "R2 stall with far jump");
    issue(0, 1, 0, 9'h140, 13'h0333, "R2 stall with call");
    issue(0, 0, 1, 9'h000, 13'h0, "R2 stall with return");

    // R8 / R4: far jumps and bit 13 retention
    issue(1, 1, 0, 9'h101, 13'h0123, "R8 far jump high");
    fa = 6'b000001;
    issue(1, 1, 0, 9'h082, 13'h0456, "R4 taken branch keeps bit13");
    issue(1, 1, 0, 9'h100, 13'h1ABC, "R8 far jump low");
    issue(1, 1, 0, 9'h080, 13'h0999, "R4 false condition increments");

    // R5: all flag tests under several flag patterns
    for (int p = 0; p < 3; p++) begin
      case (p)
        0: begin fa = 6'h00; fb = 6'h3F; end
        1: begin fa = 6'h3F; fb = 6'h00; end
        default: begin fa = 6'h15; fb = 6'h2A; end
      endcase
      for (int t = 'h80; t <= 'hAE; t += 2)
        issue(1, 1, 0, 9'(t), 13'(t * 37 + p), "R5 flag condition");
    end

    // R6: data pointer nibble tests
    for (int d = 0; d < 3; d++) begin
      dpn = (d == 0) ? 4'h0 : (d == 1) ? 4'h5 : 4'hF;
      for (int t = 'hB0; t <= 'hB3; t++)
        issue(1, 1, 0, 9'(t), 13'(t * 11 + d), "R6 nibble condition");
    end

    // R7: status bit tests
    for (int s = 0; s < 3; s++) begin
      {sic, soc, rqm} = (s == 0) ? 3'b000 : (s == 1) ? 3'b111 : 3'b101;
      for (int t = 'hB4; t <= 'hBE; t += 2)
        issue(1, 1, 0, 9'(t), 13'(t * 5 + s), "R7 status condition");
    end

    // R12: undefined types and jump priority over return
    issue(1, 1, 0, 9'h081, 13'h0111, "R12 undefined odd type");
    issue(1, 1, 0, 9'h0C0, 13'h0222, "R12 undefined type 0C0");
    issue(1, 1, 0, 9'h0B5, 13'h0333, "R12 undefined type 0B5");
    issue(1, 1, 0, 9'h1FF, 13'h0444, "R12 undefined type 1FF");
    issue(1, 1, 0, 9'h001, 13'h0555, "R12 undefined type 001");
    issue(1, 1, 1, 9'h100, 13'h0666, "R12 jump wins over return");

    // R11: indirect through serial-out register
    sout = 14'h2ABC;
    issue(1, 1, 0, 9'h000, 13'h0, "R11 serial-out jump");

    // R3 wrap and R4 bit13 from incremented pc
    issue(1, 1, 0, 9'h101, 13'h1FFF, "R8 far jump to 3FFF");
    issue(1, 0, 0, 9'h000, 13'h0, "R3 wrap 3FFF to 0000");
    issue(1, 1, 0, 9'h100, 13'h1FFF, "R8 far jump to 1FFF");
    fa = 6'b000001;
    issue(1, 1, 0, 9'h082, 13'h0010, "R4 bit13 from pc+1 at 1FFF");

    // R9 / R10: five calls into a four-deep stack, then unwind
    for (int c = 0; c < 5; c++)
      issue(1, 1, 0, (c % 2 == 0) ? 9'h140 : 9'h141, 13'(c * 256 + 3), "R9 call push and wrap");
    for (int c = 0; c < 5; c++)
      issue(1, 0, 1, 9'h000, 13'h0, "R10 return pop and wrap");

    // R1: reset in the middle of a run
    issue(1, 1, 0, 9'h141, 13'h0042, "R9 call before reset");
    rst = 1'b1;
    @(posedge clk);
    #1 rst = 1'b0;
    m_pc = '0; m_sp = '0;
    check_reset("R1 mid-run reset");

    while (q_pc.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule